// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the device-side command interpreter of a byte-wide parallel NOR flash model. It watches bus write cycles formed from the active-low chip-enable and write-enable strobes and walks through the multi-cycle unlock sequence that leads to a sector erase. It keeps a bitmap of the sectors picked for erase and reports the device mode. The array, the program algorithm and the analog erase are not part of it. A busy counter stands in for the time the erase takes.

After the sixth cycle of the erase sequence, the block keeps a timed window open. During this window more sector addresses can be added. When the window lapses with no new write started, erasing begins. A reset byte is honoured only while the sequence is still being entered. Once erasing has begun, only the suspend byte is accepted. While suspended, a read aimed at a selected sector flags status, and a read aimed at any other sector returns array data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read-array), `sect_sel` is all zero and `rd_status` is 0.
- R2: The writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h followed by 30h to any address put the block in mode 3 (load window) with bit `addr[ADDR_W-1 -: SECT_W]` of that last address set in `sect_sel`. Unlock addresses compare only the low 11 address bits. Mode codes: 0 read-array, 1 unlock in progress, 2 erase setup, 3 load window, 4 erasing, 5 suspended.
- R3: A write's address is the one present when the later of `ce_n`/`we_n` goes low. Its data is the value present in the last clock in which both strobes are low.
- R4: Each further 30h write in the load window adds its sector and restarts the window. The window is `CLK_MHZ*WINDOW_US` clocks of an idle bus. When it lapses, mode becomes 4.
- R5: In the load window, any byte other than 30h or B0h returns the block to mode 0 and clears `sect_sel`.
- R6: The byte F0h written to any address at any step before erasing returns the block to mode 0.
- R7: An unlock write whose low address bits or data do not match the expected pair returns the block to mode 0.
- R8: While erasing, F0h and every byte other than B0h are ignored.
- R9: B0h in mode 3 or mode 4 gives mode 5 and freezes the erase progress. In mode 5, `rd_status` is 1 only when `addr` falls in a selected sector. Writing 30h resumes erasing.
- R10: Erasing lasts `ERASE_CYC` clocks per selected sector. The block then returns to mode 0 with `sect_sel` cleared.
- R11: If erase completion and a B0h write end in the same clock, completion wins and the block enters mode 0.
- R12: In mode 4, `rd_status` is 1 for every address. In modes 0 to 3 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address for writes and reads |
| data | input | 8 | Write data byte |
| mode | output | 3 | Current mode code (see R2) |
| sect_sel | output | 2**SECT_W | Sectors selected for erase |
| rd_status | output | 1 | A read at `addr` would return status |

## Verification
Two functions can land in the same clock: the erase busy counter reaching its end, and a suspend write finishing on the bus. The bench counts clocks from the last sector write, through the window and the erase length, and ends a B0h write exactly on the completion edge. It then expects read-array mode with an empty sector map rather than suspension. The window lapsing cannot coincide with a write ending, because a write in progress holds the window, and that pause is covered by the random multi-sector runs.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_SETUP, ST_UNL3, ST_UNL4,
    ST_LOAD, ST_ERASE, ST_SUSP
  } seq_state_t;

  localparam logic [2:0] MODE_READ   = 3'd0;
  localparam logic [2:0] MODE_UNLOCK = 3'd1;
  localparam logic [2:0] MODE_SETUP  = 3'd2;
  localparam logic [2:0] MODE_LOAD   = 3'd3;
  localparam logic [2:0] MODE_ERASE  = 3'd4;
  localparam logic [2:0] MODE_SUSP   = 3'd5;

  localparam logic [7:0] BYTE_UNL_A  = 8'hAA;
  localparam logic [7:0] BYTE_UNL_B  = 8'h55;
  localparam logic [7:0] BYTE_SETUP  = 8'h80;
  localparam logic [7:0] BYTE_SECTOR = 8'h30;
  localparam logic [7:0] BYTE_SUSP   = 8'hB0;
  localparam logic [7:0] BYTE_RESET  = 8'hF0;

  localparam int unsigned UNLOCK_W   = 11;
  localparam logic [UNLOCK_W-1:0] ADR_UNL_A = 11'h555;
  localparam logic [UNLOCK_W-1:0] ADR_UNL_B = 11'h2AA;

  function automatic logic [2:0] mode_of(seq_state_t s);
    case (s)
      ST_UNL1, ST_UNL2:          mode_of = MODE_UNLOCK;
      ST_SETUP, ST_UNL3, ST_UNL4: mode_of = MODE_SETUP;
      ST_LOAD:                   mode_of = MODE_LOAD;
      ST_ERASE:                  mode_of = MODE_ERASE;
      ST_SUSP:                   mode_of = MODE_SUSP;
      default:                   mode_of = MODE_READ;
    endcase
  endfunction

  function automatic int unsigned window_cycles(int unsigned mhz, int unsigned us);
    window_cycles = mhz * us;
  endfunction

  function automatic int unsigned erase_len(int unsigned per_sector, int unsigned nsect);
    erase_len = per_sector * nsect;
  endfunction

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              wr_active,
  output logic              wr_start,
  output logic              wr_end,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [7:0]        cap_data
);
  logic wr_q;

  // both strobes low forms a write; edges of that window mark capture points
  assign wr_active = ~ce_n & ~we_n;
  assign wr_start  = wr_active & ~wr_q;
  assign wr_end    = ~wr_active & wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      wr_q <= wr_active;
      if (wr_start)  cap_addr <= addr;
      if (wr_active) cap_data <= data;
    end
  end

  p_addr_at_later_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> cap_addr == $past(addr));

  p_data_last_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active |=> cap_data == $past(data));

endmodule

// File: rtl/fcd_countdown.sv
module fcd_countdown #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (run && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && !zero) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned SECT_W    = 3,
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned WINDOW_US = 50,
  parameter int unsigned ERASE_CYC = 400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  we_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            data,
  output logic [2:0]            mode,
  output logic [(1<<SECT_W)-1:0] sect_sel,
  output logic                  rd_status
);
  localparam int unsigned NSECT   = 1 << SECT_W;
  localparam int unsigned WIN_CYC = window_cycles(CLK_MHZ, WINDOW_US);
  localparam int unsigned WIN_W   = $clog2(WIN_CYC + 1);
  localparam int unsigned BUSY_W  = $clog2(erase_len(ERASE_CYC, NSECT) + 1);

  logic              wr_active, wr_start, wr_end;
  logic [ADDR_W-1:0] cap_addr;
  logic [7:0]        cap_data;

  fcd_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .data(data),
    .wr_active(wr_active), .wr_start(wr_start), .wr_end(wr_end),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  seq_state_t st, st_n;
  logic [NSECT-1:0] sel_q, sel_n;

  // named internal events
  logic cmd_ev, is_unl_a, is_unl_b, is_setup, is_sector, is_susp, is_reset;
  logic [SECT_W-1:0] ev_sect, rd_sect;
  logic set_bit, win_load, win_run, win_zero, win_expire;
  logic busy_load, busy_run, busy_zero, erase_done;
  logic [WIN_W-1:0]  win_cnt;
  logic [BUSY_W-1:0] busy_cnt, busy_init;
  logic unused_addr_bits;

  assign cmd_ev    = wr_end;
  assign ev_sect   = cap_addr[ADDR_W-1 -: SECT_W];
  assign rd_sect   = addr[ADDR_W-1 -: SECT_W];
  assign is_unl_a  = cap_addr[UNLOCK_W-1:0] == ADR_UNL_A && cap_data == BYTE_UNL_A;
  assign is_unl_b  = cap_addr[UNLOCK_W-1:0] == ADR_UNL_B && cap_data == BYTE_UNL_B;
  assign is_setup  = cap_addr[UNLOCK_W-1:0] == ADR_UNL_A && cap_data == BYTE_SETUP;
  assign is_sector = cap_data == BYTE_SECTOR;
  assign is_susp   = cap_data == BYTE_SUSP;
  assign is_reset  = cap_data == BYTE_RESET;
  assign unused_addr_bits = ^cap_addr;

  assign win_run    = (st == ST_LOAD) && !wr_active;
  assign win_expire = (st == ST_LOAD) && !wr_active && !wr_end && win_zero;
  assign busy_run   = (st == ST_ERASE);
  assign erase_done = (st == ST_ERASE) && busy_zero;
  assign busy_init  = BUSY_W'(erase_len(ERASE_CYC, $countones(sel_q)) - 1);

  always_comb begin
    st_n      = st;
    set_bit   = 1'b0;
    win_load  = 1'b0;
    busy_load = 1'b0;
    case (st)
      ST_READ:  if (cmd_ev) st_n = is_unl_a ? ST_UNL1 : ST_READ;
      ST_UNL1:  if (cmd_ev) st_n = (is_unl_b && !is_reset) ? ST_UNL2 : ST_READ;
      ST_UNL2:  if (cmd_ev) st_n = is_setup ? ST_SETUP : ST_READ;
      ST_SETUP: if (cmd_ev) st_n = is_unl_a ? ST_UNL3 : ST_READ;
      ST_UNL3:  if (cmd_ev) st_n = is_unl_b ? ST_UNL4 : ST_READ;
      ST_UNL4: begin
        if (cmd_ev) begin
          if (is_sector) begin
            st_n = ST_LOAD; set_bit = 1'b1; win_load = 1'b1;
          end else begin
            st_n = ST_READ;
          end
        end
      end
      ST_LOAD: begin
        if (cmd_ev) begin
          if (is_sector) begin
            set_bit = 1'b1; win_load = 1'b1;
          end else if (is_susp) begin
            st_n = ST_SUSP; busy_load = 1'b1;
          end else begin
            st_n = ST_READ;
          end
        end else if (win_expire) begin
          st_n = ST_ERASE; busy_load = 1'b1;
        end
      end
      ST_ERASE: begin
        if (erase_done)            st_n = ST_READ;
        else if (cmd_ev && is_susp) st_n = ST_SUSP;
      end
      ST_SUSP:  if (cmd_ev && is_sector) st_n = ST_ERASE;
      default:  st_n = ST_READ;
    endcase
  end

  always_comb begin
    sel_n = sel_q;
    if (st_n == ST_READ) sel_n = '0;
    else if (set_bit)    sel_n[ev_sect] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_READ;
      sel_q <= '0;
    end else begin
      st    <= st_n;
      sel_q <= sel_n;
    end
  end

  fcd_countdown #(.W(WIN_W)) u_window (
    .clk(clk), .rst_n(rst_n), .load(win_load),
    .load_val(WIN_W'(WIN_CYC - 1)), .run(win_run),
    .cnt(win_cnt), .zero(win_zero)
  );

  fcd_countdown #(.W(BUSY_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(busy_load),
    .load_val(busy_init), .run(busy_run),
    .cnt(busy_cnt), .zero(busy_zero)
  );

  assign mode      = mode_of(st);
  assign sect_sel  = sel_q;
  assign rd_status = (st == ST_ERASE) || ((st == ST_SUSP) && sel_q[rd_sect]);

  // assertions next to the sequencing logic
  p_read_map_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_READ) |-> (sect_sel == '0));

  p_sector_enters_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UNL4 && cmd_ev && is_sector) |=> (mode == MODE_LOAD && sect_sel != '0));

  p_expire_starts_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> (mode == MODE_ERASE));

  p_erase_ignores_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && cmd_ev && is_reset && !busy_zero) |=> (mode == MODE_ERASE));

  p_suspend_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && !(cmd_ev && is_sector)) |=> $stable(busy_cnt));

  p_done_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> (mode == MODE_READ));

  p_window_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD && wr_active) |=> $stable(win_cnt));

  p_status_in_erase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ERASE) |-> rd_status);

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int SECT_W = 3;
  localparam int CLK_MHZ = 2;
  localparam int WINDOW_US = 50;
  localparam int ERASE_CYC = 40;
  localparam int NSECT = 1 << SECT_W;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] data = '0;
  logic [2:0] mode;
  logic [NSECT-1:0] sect_sel;
  logic rd_status;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CLK_MHZ(CLK_MHZ),
    .WINDOW_US(WINDOW_US), .ERASE_CYC(ERASE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .data(data), .mode(mode), .sect_sel(sect_sel), .rd_status(rd_status));

  function automatic int win_len();
    return CLK_MHZ * WINDOW_US;
  endfunction

  function automatic int erase_time(logic [NSECT-1:0] m);
    int n = 0;
    for (int i = 0; i < NSECT; i++) if (m[i]) n++;
    return ERASE_CYC * n;
  endfunction

  function automatic logic [ADDR_W-1:0] sect_addr(int s, logic [15:0] low);
    return {s[SECT_W-1:0], low};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; data = d; ce_n = 0; we_n = 0;
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic prefix();
    bus_wr(19'h555, 8'hAA); bus_wr(19'h2AA, 8'h55); bus_wr(19'h555, 8'h80);
    bus_wr(19'h555, 8'hAA); bus_wr(19'h2AA, 8'h55);
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NSECT-1:0] m;
    int w, l;
    void'($urandom(32'd20240611));
    w = win_len();
    wait_neg(3);
    check("R1 mode", mode, 0);
    check("R1 sel", sect_sel, 0);
    check("R1 status", rd_status, 0);
    rst_n = 1;
    wait_neg(2);

    // R2 / R6: partial sequences and reset
    bus_wr(19'h555, 8'hAA);
    check("R2 unlock mode", mode, 1);
    bus_wr(19'h7_1234, 8'hF0);
    check("R6 reset in unlock", mode, 0);
    bus_wr(19'h555, 8'hAA); bus_wr(19'h2AA, 8'h55); bus_wr(19'h555, 8'h80);
    check("R2 setup mode", mode, 2);
    bus_wr(19'h3_0000, 8'hF0);
    check("R6 reset in setup", mode, 0);

    // R7: unlock mismatches
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (d == 8'hAA) d = 8'h11;
      bus_wr(19'h555, 8'hAA);
      bus_wr(19'h2AA, d);
      check("R7 bad unlock data", mode, 0);
      bus_wr(19'h555, 8'hAA);
      bus_wr(19'h2AB, 8'h55);
      check("R7 bad unlock addr", mode, 0);
    end

    // R3: address at later falling edge, data at last active clock
    prefix();
    @(negedge clk); addr = sect_addr(2, 0); data = 8'h12; ce_n = 0;
    @(negedge clk); addr = sect_addr(5, 0); we_n = 0;
    @(negedge clk); addr = sect_addr(7, 0); data = 8'h30;
    @(negedge clk); ce_n = 1; we_n = 1; data = 8'h00;
    @(negedge clk);
    check("R3 captured sector", sect_sel, 8'h20);
    check("R2 load mode", mode, 3);
    check("R12 no status in load", rd_status, 0);
    // R5: other byte in load window
    bus_wr(sect_addr(1, 0), 8'h44);
    check("R5 other byte exits", mode, 0);
    check("R5 map cleared", sect_sel, 0);

    // R6 in load window with F0
    prefix(); bus_wr(sect_addr(4, 0), 8'h30);
    bus_wr(19'h6_5555, 8'hF0);
    check("R6 reset in load", mode, 0);

    // R4 / R10 random multi-sector erases
    for (int it = 0; it < 5; it++) begin
      m = NSECT'($urandom);
      if (m == 0) m = 1;
      prefix();
      for (int s = 0; s < NSECT; s++) if (m[s]) bus_wr(sect_addr(s, 16'($urandom)), 8'h30);
      check("R4 map accumulates", sect_sel, m);
      l = erase_time(m);
      wait_neg(w - 2);
      check("R4 window still open", mode, 3);
      wait_neg(3);
      check("R4 window lapsed", mode, 4);
      addr = 19'($urandom);
      @(negedge clk);
      check("R12 status in erase", rd_status, 1);
      wait_neg(l - 5);
      check("R10 still erasing", mode, 4);
      wait_neg(3);
      check("R10 done", mode, 0);
      check("R10 map cleared", sect_sel, 0);
    end

    // R8 / R9: ignore reset, suspend, resume
    prefix(); bus_wr(sect_addr(1, 0), 8'h30);
    wait_neg(w + 2);
    check("R9 pre erase", mode, 4);
    bus_wr(19'h555, 8'hF0);
    check("R8 reset ignored", mode, 4);
    bus_wr(19'h555, 8'h44);
    check("R8 other ignored", mode, 4);
    bus_wr(19'h0, 8'hB0);
    check("R9 suspended", mode, 5);
    addr = sect_addr(1, 16'h0100); @(negedge clk);
    check("R9 status in selected", rd_status, 1);
    addr = sect_addr(3, 16'h0100); @(negedge clk);
    check("R9 array elsewhere", rd_status, 0);
    wait_neg(3 * ERASE_CYC);
    check("R9 frozen", mode, 5);
    bus_wr(19'h0, 8'hF0);
    check("R9 reset ignored in suspend", mode, 5);
    bus_wr(19'h0, 8'h30);
    check("R9 resumed", mode, 4);
    wait_neg(ERASE_CYC + 5);
    check("R9 completes after resume", mode, 0);

    // R9: suspend inside load window
    prefix(); bus_wr(sect_addr(6, 0), 8'h30);
    bus_wr(19'h0, 8'hB0);
    check("R9 suspend in load", mode, 5);
    bus_wr(19'h0, 8'h30);
    wait_neg(ERASE_CYC + 5);
    check("R9 load suspend resumes", mode, 0);

    // R11: completion and suspend in the same clock
    prefix(); bus_wr(sect_addr(3, 0), 8'h30);
    l = erase_time(8'h08);
    wait_neg(w + l - 2);
    addr = 19'h0; data = 8'hB0; ce_n = 0; we_n = 0;
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk);
    check("R11 completion wins", mode, 0);
    check("R11 map cleared", sect_sel, 0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule